// File: doc/BRIEF.md
# Heartbeat Watchdog and Supervisor Reset

This block drives the active-low reset line of a host processor. It combines two supervision duties. The first is a filtered supply-low monitor: a digital undervoltage flag from an external comparator must persist before the block raises an internal supply-low (NMI) flag. While that flag is up the processor is held in reset, and it is let go a fixed time after the supply recovers. The second is a heartbeat monitor: the processor must toggle a pulse input, and only rising edges count. If no rising edge arrives within the timeout, the block emits a repeating train of reset pulses until the processor produces an edge again.

A strap input (`wd_off`, high = disable) masks heartbeat faults only. Undervoltage still resets the processor when the strap is high. All timing counts cycles of the free-running clock (10 MHz nominal), and every interval is a parameter. The heartbeat input is synchronised through two flops before edge detection, so pulses shorter than about two clock periods may be missed.

Top module: `hb_reset_gen`

## Requirements
- R1: While `por_n` is low, `rst_n_o` is low and `vlow_o` is low. After `por_n` rises, `rst_n_o` goes high exactly `REL_CYC` clock edges later, provided `vlow_o` stays low. No heartbeat timeout runs during that hold.
- R2: `vlow_o` (high = supply low) rises on the `UV_FILT_CYC`-th consecutive clock edge at which `uv_in` is high. A dip lasting fewer edges leaves both `vlow_o` and `rst_n_o` unchanged.
- R3: `rst_n_o` is low in the same cycle that `vlow_o` rises. It stays low until `REL_CYC` edges after `vlow_o` falls.
- R4: An undervoltage reset occurs regardless of the level of `wd_off`.
- R5: Only a rising edge of `hb_in`, seen after a two-flop synchroniser, restarts the heartbeat timer. A level held steadily high or steadily low is a fault.
- R6: In normal operation, if no heartbeat edge takes effect for `TMO_CYC` edges, `rst_n_o` goes low. Measured from an input rise driven between clock edges, this is `TMO_CYC`+3 edges.
- R7: During a heartbeat fault, `rst_n_o` repeats a low phase of `PLO_CYC` cycles followed by a high phase of `PHI_CYC` cycles.
- R8: A heartbeat edge during the high phase of the train returns the block to normal monitoring and stops the train. An edge during the low phase does not shorten that low phase.
- R9: While `wd_off` is high, heartbeat faults never pull `rst_n_o` low. Raising `wd_off` during the low phase of the train releases `rst_n_o` at the next clock edge.
- R10: `vlow_o` falls at the first clock edge at which `uv_in` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timing clock |
| por_n | input | 1 | Raw power-on reset, active low, asynchronous |
| hb_in | input | 1 | Heartbeat pulse from the host processor (asynchronous) |
| wd_off | input | 1 | Strap; high masks heartbeat faults |
| uv_in | input | 1 | Comparator flag, high while the supply is under threshold |
| rst_n_o | output | 1 | Reset to the host processor, active low |
| vlow_o | output | 1 | Filtered supply-low flag, active high |

## Verification
On every cycle, the embedded assertions check the following. A raised supply-low flag is followed by a low reset. The flag never stays up once the comparator input drops. With the strap high, a released reset is never pulled low except by undervoltage. Reset only rises out of the hold or the pulse-low phase, and the heartbeat timer never passes its limit. The exact interval lengths need the bench's scenarios: the release delay, the timeout counted from an asynchronous input rise, the low and high widths of the pulse train, the rejection of every dip length shorter than the filter, and the different effect of a heartbeat edge in each half of the train. All of these run on a shrunken configuration so that each interval can be counted cycle by cycle.

// File: rtl/hb_reset_gen.sv
module hb_reset_gen #(
  parameter int UV_FILT_CYC = 715,
  parameter int REL_CYC     = 400000,
  parameter int TMO_CYC     = 800000,
  parameter int PLO_CYC     = 200000,
  parameter int PHI_CYC     = 800000
) (
  input  logic clk,
  input  logic por_n,
  input  logic hb_in,
  input  logic wd_off,
  input  logic uv_in,
  output logic rst_n_o,
  output logic vlow_o
);

  localparam int M1   = (REL_CYC > TMO_CYC) ? REL_CYC : TMO_CYC;
  localparam int M2   = (PLO_CYC > PHI_CYC) ? PLO_CYC : PHI_CYC;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int UW   = $clog2(UV_FILT_CYC + 1);

  typedef enum logic [1:0] {ST_HOLD, ST_RUN, ST_PLO, ST_PHI} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [UW-1:0] uv_cnt;
  logic          hb_s1, hb_s2, hb_d;
  logic          hb_edge;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) {hb_s1, hb_s2, hb_d} <= 3'b000;
    else        {hb_s1, hb_s2, hb_d} <= {hb_in, hb_s1, hb_s2};

  assign hb_edge = hb_s2 & ~hb_d;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      uv_cnt <= '0;
      vlow_o <= 1'b0;
    end else if (!uv_in) begin
      uv_cnt <= '0;
      vlow_o <= 1'b0;
    end else if (uv_cnt == UW'(UV_FILT_CYC - 1)) begin
      vlow_o <= 1'b1;
    end else begin
      uv_cnt <= uv_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      st  <= ST_HOLD;
      cnt <= '0;
    end else if (vlow_o) begin
      st  <= ST_HOLD;
      cnt <= '0;
    end else begin
      case (st)
        ST_HOLD:
          if (cnt == CW'(REL_CYC - 1)) begin st <= ST_RUN; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        ST_RUN:
          if (hb_edge) cnt <= '0;
          else if (cnt == CW'(TMO_CYC - 1)) begin
            cnt <= '0;
            if (!wd_off) st <= ST_PLO;
          end else cnt <= cnt + 1'b1;
        ST_PLO:
          if (wd_off) begin st <= ST_RUN; cnt <= '0; end
          else if (cnt == CW'(PLO_CYC - 1)) begin st <= ST_PHI; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default:
          if (hb_edge || wd_off) begin st <= ST_RUN; cnt <= '0; end
          else if (cnt == CW'(PHI_CYC - 1)) begin st <= ST_PLO; cnt <= '0; end
          else cnt <= cnt + 1'b1;
      endcase
    end

  assign rst_n_o = (st == ST_RUN || st == ST_PHI) && !vlow_o;

  assert_vlow_forces_reset_R3: assert property (@(posedge clk) disable iff (!por_n)
    vlow_o |=> !rst_n_o);

  assert_flag_drops_R10: assert property (@(posedge clk) disable iff (!por_n)
    !uv_in |=> !vlow_o);

  assert_strap_masks_R9: assert property (@(posedge clk) disable iff (!por_n)
    (wd_off && rst_n_o) |=> (rst_n_o || vlow_o));

  assert_release_origin_R1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_n_o) |-> ($past(st) == ST_HOLD || $past(st) == ST_PLO));

  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!por_n)
    (st == ST_RUN) |-> (cnt < CW'(TMO_CYC)));

endmodule

// File: tb/hb_reset_gen_bench.sv
`timescale 1ns/1ps
module hb_reset_gen_bench;
  localparam int UV  = 5;
  localparam int REL = 40;
  localparam int TMO = 60;
  localparam int LO  = 10;
  localparam int HI  = 30;

  logic clk = 1'b0;
  logic por_n, hb_in, wd_off, uv_in;
  logic rst_n_o, vlow_o;

  int checks = 0, fails = 0;
  int lo_run = 0, hi_run = 0, last_lo = 0, last_hi = 0;
  int n_fall = 0, n_vrise = 0;
  logic vprev = 1'b0;

  always #2.5 clk = ~clk;

  hb_reset_gen #(.UV_FILT_CYC(UV), .REL_CYC(REL), .TMO_CYC(TMO),
                 .PLO_CYC(LO), .PHI_CYC(HI)) u_hb_reset_gen (
    .clk(clk), .por_n(por_n), .hb_in(hb_in), .wd_off(wd_off), .uv_in(uv_in),
    .rst_n_o(rst_n_o), .vlow_o(vlow_o));

  always @(posedge clk) begin
    #1;
    if (rst_n_o === 1'b1) begin
      if (lo_run > 0) begin last_lo = lo_run; lo_run = 0; end
      hi_run++;
    end else begin
      if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; n_fall++; end
      lo_run++;
    end
    if (vlow_o === 1'b1 && vprev !== 1'b1) n_vrise++;
    vprev = vlow_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rst(input logic v, output int n);
    n = 0;
    do begin @(posedge clk); #2; n++; end while (rst_n_o !== v && n < 5000);
  endtask

  task automatic hb_toggle();
    @(negedge clk) hb_in = 1'b0;
    @(negedge clk) hb_in = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog R1: run incomplete, got 0 expected 1");
    summary();
  end

  initial begin
    int n, f0, v0;
    por_n = 1'b0; hb_in = 1'b0; wd_off = 1'b0; uv_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(rst_n_o === 1'b0, "R1 reset low in por", rst_n_o, 0);
    chk(vlow_o === 1'b0, "R1 flag low in por", vlow_o, 0);
    @(negedge clk) por_n = 1'b1;
    wait_rst(1'b1, n);
    chk(n == REL, "R1 release delay", n, REL);

    f0 = n_fall;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk) hb_in = 1'b1;
      repeat (2) @(negedge clk);
      hb_in = 1'b0;
      repeat (17) @(negedge clk);
    end
    chk(n_fall == f0, "R5 regular heartbeat keeps reset high", n_fall - f0, 0);

    @(negedge clk) hb_in = 1'b1;
    wait_rst(1'b0, n);
    chk(n == TMO + 3, "R6 timeout with input stuck high", n, TMO + 3);

    for (int k = 0; k < 3; k++) begin
      wait_rst(1'b1, n);
      chk(last_lo == LO, "R7 train low width", last_lo, LO);
      wait_rst(1'b0, n);
      chk(last_hi == HI, "R7 train high width", last_hi, HI);
    end

    hb_toggle();
    wait_rst(1'b1, n);
    chk(last_lo == LO, "R8 edge in low phase ignored", last_lo, LO);

    hb_toggle();
    f0 = n_fall;
    repeat (HI + 10) @(negedge clk);
    chk(n_fall == f0 && rst_n_o === 1'b1, "R8 edge in high phase stops train", n_fall - f0, 0);
    wait_rst(1'b0, n);
    chk(n < 5000, "R8 timeout resumes after restart", n, TMO);

    @(negedge clk) wd_off = 1'b1;
    wait_rst(1'b1, n);
    chk(n == 1, "R9 strap ends low phase", n, 1);
    f0 = n_fall;
    repeat (3 * TMO) @(negedge clk);
    chk(n_fall == f0, "R9 strap masks stuck heartbeat", n_fall - f0, 0);

    v0 = n_vrise;
    for (int d = 1; d < UV; d++) begin
      @(negedge clk) uv_in = 1'b1;
      repeat (d) @(negedge clk);
      uv_in = 1'b0;
      repeat (3) @(negedge clk);
      chk(n_vrise == v0 && n_fall == f0, "R2 short dip ignored", d, 0);
    end

    @(negedge clk) uv_in = 1'b1;
    n = 0;
    do begin @(posedge clk); #2; n++; end while (vlow_o !== 1'b1 && n < 5000);
    chk(n == UV, "R2 filter length", n, UV);
    chk(rst_n_o === 1'b0, "R3 reset low with flag", rst_n_o, 0);
    chk(wd_off === 1'b1 && rst_n_o === 1'b0, "R4 undervoltage overrides strap", rst_n_o, 0);
    repeat (10) @(negedge clk);
    chk(rst_n_o === 1'b0, "R3 reset held during undervoltage", rst_n_o, 0);
    @(negedge clk) uv_in = 1'b0;
    @(posedge clk); #2;
    chk(vlow_o === 1'b0, "R10 flag clears next edge", vlow_o, 0);
    wait_rst(1'b1, n);
    chk(n == REL, "R3 release after recovery", n, REL);

    summary();
  end
endmodule